// File: doc/BRIEF.md
# Packet Timestamp Capture Unit

This unit sits beside a port's time counter and records the counter value at the moment a timestamp-worthy packet passes. The packet parser upstream supplies a one-cycle event strobe for each direction. For receive events it also supplies three attributes: the protocol version, the message type and whether the message arrived over UDP. The unit applies a configurable receive filter. It stores each accepted receive time in the lowest-numbered free slot of a small bank and returns that slot number with the packet, so that software can later fetch the matching time. A single transmit capture register holds the time of the last timestamped outgoing packet. It can raise an interrupt.

Every capture is kept by a two-state machine per slot. The states are `SLOT_FREE` and `SLOT_HELD`. The transition FREE→HELD is taken on an accepted event, and the stored time is written on that same transition. The transition HELD→FREE is taken on a release. For a receive slot, the release is a read of that slot's high word. For the transmit register, the release is a read of its high word or of the transmit status register. While a slot is HELD, new events cannot overwrite it. When every receive slot is HELD, an accepted packet is reported without an index and a sticky overflow flag is set.

Software uses a simple register port with word addresses. A read is accepted in the cycle `reg_rd` is high. The data appears on `reg_rdata` one cycle later, together with `reg_rvalid`, and any release caused by that read takes effect at the same clock edge.

Top module: `tsu_capture_top`

## Requirements
- R1: After reset every slot is FREE. The control register, the transmit status, the receive status, `tx_irq` and `rx_tag_valid` are all 0. Reads of unmapped addresses (5, 6, 7) return 0.
- R2: A capture stores the `time_now` value present in the cycle of the event strobe. A read of the low-word address returns bits 31:0 of the stored time, and a read of the high-word address returns bits 63:32. For transmit, the low word is at address 3 and the high word at address 4. For receive slot k, the low word is at address 8+2k and the high word at 9+2k.
- R3: An accepted receive packet takes the lowest-numbered FREE slot. One cycle after `rx_event`, the outputs are `rx_tag_valid`=1, `rx_tag_has_ts`=1 and `rx_tag_slot`=k.
- R4: A receive slot stays HELD, and its stored time stays unchanged, until its high word is read. Reading its low word or the status register does not release it.
- R5: If no slot is FREE, an accepted packet is reported with `rx_tag_has_ts`=0 and `rx_tag_slot`=0, and no slot changes. The overflow flag is set; it is bit 4 of the receive status at address 2. A read of address 2 clears the flag.
- R6: The control register is at address 0, with these fields:
  - bits 1:0 select the version; 1 or 2 selects that version, and 0 or 3 accepts nothing.
  - bit 2 enables message-type filtering.
  - bits 6:3 hold the message type to match.
  - bit 7 enables UDP-carried messages.
  - bit 8 enables the transmit interrupt.

  A receive packet is accepted only if all of these hold: its version equals a valid selection, its type matches when filtering is on, and it is not UDP-carried unless UDP is enabled. A packet that is not accepted still produces `rx_tag_valid`, with `rx_tag_has_ts`=0, and it sets no overflow.
- R7: A `tx_event` while the transmit register is FREE captures the time, and transmit status bit 0 at address 1 becomes 1. A `tx_event` while the register is HELD leaves the stored time unchanged.
- R8: A read of the transmit status at address 1, or of the transmit high word at address 4, returns the current value and then releases the transmit register.
- R9: `tx_irq` is 1 exactly when control bit 8 is 1 and the transmit register is HELD.
- R10: Receive status bits 3:0 show, per slot, whether that slot is HELD.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| time_now | input | 64 | Current time counter value |
| tx_event | input | 1 | Transmit timestamp strobe |
| rx_event | input | 1 | Receive event-packet strobe |
| rx_ver | input | 2 | Protocol version of the received packet |
| rx_msg_type | input | 4 | Message type of the received packet |
| rx_udp | input | 1 | Received packet was carried over UDP |
| rx_tag_valid | output | 1 | Tag for the packet strobed in the previous cycle |
| rx_tag_has_ts | output | 1 | The tagged packet has a stored timestamp |
| rx_tag_slot | output | 2 | Slot holding that timestamp |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | 5 | Register word address |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, one cycle after `reg_rd` |
| reg_rvalid | output | 1 | `reg_rdata` is valid |
| tx_irq | output | 1 | Transmit capture interrupt |

## Verification
The bench builds the unit with its default parameters: four receive slots, a 64-bit time and 32-bit register words. Four slots are few enough that a short run of matching packets fills the bank, so the overflow path and lowest-free reallocation after a scattered release come up often under random stimulus. The 64-bit random time values have independent halves, which exposes a swapped or stale word on either read.

// File: rtl/tsu_pkg.sv
package tsu_pkg;

    typedef enum logic [0:0] {
        SLOT_FREE = 1'b0,
        SLOT_HELD = 1'b1
    } slot_state_e;

    typedef struct packed {
        logic       tx_int_en;
        logic       udp_en;
        logic [3:0] msg_type;
        logic       msg_en;
        logic [1:0] ver_sel;
    } tsu_ctrl_t;

    localparam int CTRL_W   = 9;
    localparam int A_CTRL   = 0;
    localparam int A_TXST   = 1;
    localparam int A_RXST   = 2;
    localparam int A_TXLO   = 3;
    localparam int A_TXHI   = 4;
    localparam int A_RXBASE = 8;

    function automatic logic rx_filter_hit(input tsu_ctrl_t c, input logic [1:0] ver,
                                           input logic [3:0] msg, input logic udp);
        logic ver_ok;
        ver_ok = ((c.ver_sel == 2'd1) || (c.ver_sel == 2'd2)) && (ver == c.ver_sel);
        return ver_ok && (!c.msg_en || (msg == c.msg_type)) && (!udp || c.udp_en);
    endfunction

endpackage

// File: rtl/tsu_slot.sv
module tsu_slot
    import tsu_pkg::*;
#(
    parameter int TIME_W = 64
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              capture,
    input  logic              release_req,
    input  logic [TIME_W-1:0] time_in,
    output logic              held,
    output logic [TIME_W-1:0] stamp
);

    slot_state_e       state_q, state_d;
    logic [TIME_W-1:0] stamp_q;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            SLOT_FREE: if (capture)     state_d = SLOT_HELD;
            SLOT_HELD: if (release_req) state_d = SLOT_FREE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= SLOT_FREE;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                               stamp_q <= '0;
        else if (state_q == SLOT_FREE && capture) stamp_q <= time_in;
    end

    always_comb begin
        held  = (state_q == SLOT_HELD);
        stamp = stamp_q;
    end

    AST_CAPTURE_STORES: assert property (@(posedge clk) disable iff (!rst_n)
        (!held && capture) |=> (held && stamp == $past(time_in))); // R2
    AST_HELD_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        (held && !release_req) |=> (held && $stable(stamp))); // R4
    AST_RELEASE_FREES: assert property (@(posedge clk) disable iff (!rst_n)
        (held && release_req) |=> !held); // R4

endmodule

// File: rtl/tsu_alloc.sv
module tsu_alloc #(
    parameter int N = 4,
    localparam int IDX_W = $clog2(N)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req,
    input  logic [N-1:0]     held,
    output logic [N-1:0]     grant,
    output logic [IDX_W-1:0] grant_idx,
    output logic             full
);

    logic found;

    always_comb begin
        found     = 1'b0;
        grant_idx = '0;
        for (int i = 0; i < N; i++) begin
            if (!found && !held[i]) begin
                found     = 1'b1;
                grant_idx = IDX_W'(i);
            end
        end
        grant = '0;
        if (req && found) grant[grant_idx] = 1'b1;
        full = &held;
    end

    AST_ONE_GRANT: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(grant)); // R3
    AST_GRANT_FREE_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
        (grant & held) == '0); // R3
    AST_NO_GRANT_FULL: assert property (@(posedge clk) disable iff (!rst_n)
        full |-> (grant == '0)); // R5

endmodule

// File: rtl/tsu_regs.sv
module tsu_regs
    import tsu_pkg::*;
#(
    parameter int N      = 4,
    parameter int TIME_W = 64,
    parameter int DATA_W = 32,
    parameter int ADDR_W = 5
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      reg_wr,
    input  logic                      reg_rd,
    input  logic [ADDR_W-1:0]         reg_addr,
    input  logic [DATA_W-1:0]         reg_wdata,
    input  logic                      tx_held,
    input  logic [TIME_W-1:0]         tx_stamp,
    input  logic [N-1:0]              rx_held,
    input  logic [N-1:0][TIME_W-1:0]  rx_stamp,
    input  logic                      ovf_set,
    output tsu_ctrl_t                 ctrl,
    output logic [DATA_W-1:0]         reg_rdata,
    output logic                      reg_rvalid,
    output logic                      tx_release,
    output logic [N-1:0]              rx_release,
    output logic                      ovf
);

    localparam int HI_LSB = TIME_W - DATA_W;

    logic [DATA_W-1:0] rd_mux;
    logic              rxst_rd;
    logic              wdata_unused;

    assign wdata_unused = ^reg_wdata[DATA_W-1:CTRL_W];
    assign rxst_rd      = reg_rd && (reg_addr == ADDR_W'(A_RXST));

    always_comb begin
        rd_mux = '0;
        unique case (reg_addr)
            ADDR_W'(A_CTRL): rd_mux = DATA_W'(ctrl);
            ADDR_W'(A_TXST): rd_mux = DATA_W'(tx_held);
            ADDR_W'(A_RXST): rd_mux = DATA_W'({ovf, rx_held});
            ADDR_W'(A_TXLO): rd_mux = tx_stamp[DATA_W-1:0];
            ADDR_W'(A_TXHI): rd_mux = tx_stamp[TIME_W-1:HI_LSB];
            default: begin
                for (int k = 0; k < N; k++) begin
                    if (reg_addr == ADDR_W'(A_RXBASE + 2*k))
                        rd_mux = rx_stamp[k][DATA_W-1:0];
                    if (reg_addr == ADDR_W'(A_RXBASE + 2*k + 1))
                        rd_mux = rx_stamp[k][TIME_W-1:HI_LSB];
                end
            end
        endcase
    end

    always_comb begin
        tx_release = reg_rd && ((reg_addr == ADDR_W'(A_TXHI)) || (reg_addr == ADDR_W'(A_TXST)));
        for (int k = 0; k < N; k++)
            rx_release[k] = reg_rd && (reg_addr == ADDR_W'(A_RXBASE + 2*k + 1));
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctrl       <= '0;
            ovf        <= 1'b0;
            reg_rdata  <= '0;
            reg_rvalid <= 1'b0;
        end else begin
            if (reg_wr && reg_addr == ADDR_W'(A_CTRL))
                ctrl <= tsu_ctrl_t'(reg_wdata[CTRL_W-1:0]);
            if (ovf_set)      ovf <= 1'b1;
            else if (rxst_rd) ovf <= 1'b0;
            reg_rdata  <= reg_rd ? rd_mux : '0;
            reg_rvalid <= reg_rd;
        end
    end

    AST_OVF_SET: assert property (@(posedge clk) disable iff (!rst_n)
        ovf_set |=> ovf); // R5
    AST_OVF_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        (rxst_rd && !ovf_set) |=> !ovf); // R5
    AST_RVALID_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
        reg_rd |=> reg_rvalid); // R2

endmodule

// File: rtl/tsu_capture_top.sv
module tsu_capture_top
    import tsu_pkg::*;
#(
    parameter int NUM_RX_SLOTS = 4,
    parameter int TIME_W       = 64,
    parameter int DATA_W       = 32,
    parameter int ADDR_W       = 5,
    localparam int IDX_W       = $clog2(NUM_RX_SLOTS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [TIME_W-1:0] time_now,
    input  logic              tx_event,
    input  logic              rx_event,
    input  logic [1:0]        rx_ver,
    input  logic [3:0]        rx_msg_type,
    input  logic              rx_udp,
    output logic              rx_tag_valid,
    output logic              rx_tag_has_ts,
    output logic [IDX_W-1:0]  rx_tag_slot,
    input  logic              reg_wr,
    input  logic              reg_rd,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata,
    output logic              reg_rvalid,
    output logic              tx_irq
);

    tsu_ctrl_t                          ctrl;
    logic                               rx_hit;
    logic [NUM_RX_SLOTS-1:0]            rx_held, rx_grant, rx_release;
    logic [NUM_RX_SLOTS-1:0][TIME_W-1:0] rx_stamp;
    logic [IDX_W-1:0]                   grant_idx;
    logic                               rx_full;
    logic                               tx_held, tx_release;
    logic [TIME_W-1:0]                  tx_stamp;
    logic                               ovf;

    assign rx_hit = rx_event && rx_filter_hit(ctrl, rx_ver, rx_msg_type, rx_udp);

    tsu_alloc #(.N(NUM_RX_SLOTS)) alloc_i (
        .clk(clk), .rst_n(rst_n), .req(rx_hit), .held(rx_held),
        .grant(rx_grant), .grant_idx(grant_idx), .full(rx_full)
    );

    for (genvar k = 0; k < NUM_RX_SLOTS; k++) begin : g_rx_slot
        tsu_slot #(.TIME_W(TIME_W)) slot_i (
            .clk(clk), .rst_n(rst_n), .capture(rx_grant[k]),
            .release_req(rx_release[k]), .time_in(time_now),
            .held(rx_held[k]), .stamp(rx_stamp[k])
        );
    end

    tsu_slot #(.TIME_W(TIME_W)) tx_slot_i (
        .clk(clk), .rst_n(rst_n), .capture(tx_event),
        .release_req(tx_release), .time_in(time_now),
        .held(tx_held), .stamp(tx_stamp)
    );

    tsu_regs #(.N(NUM_RX_SLOTS), .TIME_W(TIME_W), .DATA_W(DATA_W), .ADDR_W(ADDR_W)) regs_i (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata),
        .tx_held(tx_held), .tx_stamp(tx_stamp),
        .rx_held(rx_held), .rx_stamp(rx_stamp),
        .ovf_set(rx_hit && rx_full), .ctrl(ctrl),
        .reg_rdata(reg_rdata), .reg_rvalid(reg_rvalid),
        .tx_release(tx_release), .rx_release(rx_release), .ovf(ovf)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rx_tag_valid  <= 1'b0;
            rx_tag_has_ts <= 1'b0;
            rx_tag_slot   <= '0;
        end else begin
            rx_tag_valid  <= rx_event;
            rx_tag_has_ts <= rx_hit && !rx_full;
            rx_tag_slot   <= (rx_hit && !rx_full) ? grant_idx : '0;
        end
    end

    assign tx_irq = ctrl.tx_int_en && tx_held;

    AST_IRQ_NEEDS_TX: assert property (@(posedge clk) disable iff (!rst_n)
        tx_irq |-> tx_held); // R9
    AST_TAG_POINTS_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_tag_valid && rx_tag_has_ts) |-> rx_held[rx_tag_slot]); // R3
    AST_TX_NO_OVERWRITE: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_held && tx_event && !tx_release) |=> $stable(tx_stamp)); // R7
    AST_FULL_FLAGS_OVF: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_hit && rx_full) |=> (ovf && !rx_tag_has_ts)); // R5

endmodule

// File: tb/tsu_capture_top_tb_top.sv
module tsu_capture_top_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [63:0] time_now = '0;
    logic        tx_event = 1'b0, rx_event = 1'b0;
    logic [1:0]  rx_ver = '0;
    logic [3:0]  rx_msg_type = '0;
    logic        rx_udp = 1'b0;
    logic        rx_tag_valid, rx_tag_has_ts;
    logic [1:0]  rx_tag_slot;
    logic        reg_wr = 1'b0, reg_rd = 1'b0;
    logic [4:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        reg_rvalid, tx_irq;

    always #10 clk = ~clk;

    tsu_capture_top dut_i (
        .clk(clk), .rst_n(rst_n), .time_now(time_now), .tx_event(tx_event),
        .rx_event(rx_event), .rx_ver(rx_ver), .rx_msg_type(rx_msg_type), .rx_udp(rx_udp),
        .rx_tag_valid(rx_tag_valid), .rx_tag_has_ts(rx_tag_has_ts), .rx_tag_slot(rx_tag_slot),
        .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata), .reg_rvalid(reg_rvalid), .tx_irq(tx_irq)
    );

    int checks = 0, errors = 0;
    bit done = 0;

    logic [8:0]  m_ctrl = '0;
    logic [3:0]  m_held = '0;
    logic [63:0] m_val [4];
    logic        m_tx_held = 0, m_ovf = 0;
    logic [63:0] m_tx_val = '0;

    task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic bit f_hit(input logic [8:0] c, input logic [1:0] v, input logic [3:0] m, input logic u);
        bit ok_v = (c[1:0] == 2'd1 || c[1:0] == 2'd2) && v == c[1:0];
        bit ok_m = !c[2] || m == c[6:3];
        bit ok_u = !u || c[7];
        return ok_v && ok_m && ok_u;
    endfunction

    function automatic int f_lowest(input logic [3:0] h);
        for (int i = 0; i < 4; i++) if (!h[i]) return i;
        return -1;
    endfunction

    function automatic logic [31:0] f_rd(input int a);
        case (a)
            0: return 32'(m_ctrl);
            1: return 32'(m_tx_held);
            2: return 32'({m_ovf, m_held});
            3: return m_tx_val[31:0];
            4: return m_tx_val[63:32];
            default: begin
                if (a >= 8 && a < 16) begin
                    if (a % 2 == 0) return m_val[(a-8)/2][31:0];
                    return m_val[(a-8)/2][63:32];
                end
                return 32'd0;
            end
        endcase
    endfunction

    task automatic chk_irq();
        chk(tx_irq == (m_ctrl[8] & m_tx_held), "R9 tx_irq", 64'(tx_irq), 64'(m_ctrl[8] & m_tx_held));
    endtask

    task automatic rd(input int a, input string req);
        logic [31:0] exp = f_rd(a);
        reg_rd = 1; reg_addr = 5'(a);
        @(negedge clk);
        reg_rd = 0;
        chk(reg_rvalid == 1'b1, "R2 rvalid", 64'(reg_rvalid), 64'd1);
        chk(reg_rdata == exp, req, 64'(reg_rdata), 64'(exp));
        if (a == 1 || a == 4) m_tx_held = 0;
        if (a == 2) m_ovf = 0;
        if (a >= 9 && a < 16 && a % 2 == 1) m_held[(a-9)/2] = 0;
        chk_irq();
    endtask

    task automatic wr(input logic [31:0] d);
        reg_wr = 1; reg_addr = 5'd0; reg_wdata = d;
        @(negedge clk);
        reg_wr = 0;
        m_ctrl = d[8:0];
        chk_irq();
    endtask

    task automatic rx_pkt(input logic [1:0] v, input logic [3:0] m, input logic u, input string req);
        logic [63:0] t = {$urandom, $urandom};
        bit hit = f_hit(m_ctrl, v, m, u);
        int s = f_lowest(m_held);
        bit has = hit && s >= 0;
        rx_event = 1; rx_ver = v; rx_msg_type = m; rx_udp = u; time_now = t;
        @(negedge clk);
        rx_event = 0;
        chk(rx_tag_valid == 1'b1, req, 64'(rx_tag_valid), 64'd1);
        chk(rx_tag_has_ts == has, req, 64'(rx_tag_has_ts), 64'(has));
        chk(rx_tag_slot == (has ? 2'(s) : 2'd0), req, 64'(rx_tag_slot), has ? 64'(s) : 64'd0);
        if (has) begin m_held[s] = 1; m_val[s] = t; end
        if (hit && s < 0) m_ovf = 1;
        chk_irq();
    endtask

    task automatic tx_pkt();
        logic [63:0] t = {$urandom, $urandom};
        tx_event = 1; time_now = t;
        @(negedge clk);
        tx_event = 0;
        if (!m_tx_held) begin m_tx_held = 1; m_tx_val = t; end
        chk_irq();
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h5eed_1234));
        for (int i = 0; i < 4; i++) m_val[i] = '0;
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        // R1 reset state
        chk(tx_irq == 0 && rx_tag_valid == 0, "R1 outputs", 64'({tx_irq, rx_tag_valid}), 64'd0);
        rd(0, "R1 ctrl"); rd(1, "R1 txst"); rd(2, "R1 rxst"); rd(6, "R1 unmapped");
        // R6 version select 0 accepts nothing, no overflow
        rx_pkt(2'd2, 4'd0, 1'b0, "R6 disabled filter");
        rd(2, "R6 no ovf");
        wr(32'h102);                        // ver 2, tx irq on, no udp, no type filter
        rx_pkt(2'd2, 4'd3, 1'b0, "R3 first slot");
        rx_pkt(2'd1, 4'd3, 1'b0, "R6 wrong version");
        rx_pkt(2'd2, 4'd3, 1'b1, "R6 udp disabled");
        wr(32'h182);                        // udp on
        rx_pkt(2'd2, 4'd5, 1'b1, "R6 udp enabled");
        rx_pkt(2'd2, 4'd1, 1'b0, "R3 third slot");
        rx_pkt(2'd2, 4'd1, 1'b0, "R3 fourth slot");
        rx_pkt(2'd2, 4'd1, 1'b0, "R5 full bank");
        rd(2, "R10 R5 status full with ovf");
        rd(2, "R5 ovf cleared");
        rd(12, "R4 low read");
        rd(2, "R4 still held");
        rd(13, "R2 high read");
        rd(2, "R10 slot2 free");
        rx_pkt(2'd2, 4'd1, 1'b0, "R3 reuse slot2");
        for (int k = 0; k < 4; k++) rd(9 + 2*k, "R4 release all");
        wr(32'h18E);                        // type filter on, type 1
        rx_pkt(2'd2, 4'd2, 1'b0, "R6 type mismatch");
        rx_pkt(2'd2, 4'd1, 1'b0, "R6 type match");
        tx_pkt();
        rd(3, "R7 tx low");
        tx_pkt();
        rd(3, "R7 tx not overwritten");
        rd(1, "R8 txst read");
        rd(1, "R8 txst cleared");
        tx_pkt();
        rd(4, "R8 tx high read");
        rd(1, "R8 cleared by high");
        for (int n = 0; n < 600; n++) begin
            int op = $urandom_range(0, 9);
            if (op < 4)
                rx_pkt(2'($urandom_range(0, 3)), 4'($urandom_range(0, 3)), 1'($urandom_range(0, 1)), "R3 R6 random rx");
            else if (op < 5) tx_pkt();
            else if (op < 9) rd($urandom_range(0, 15), "R2 R4 random read");
            else wr(32'($urandom_range(0, 511)));
        end
        done = 1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule